// File: doc/BRIEF.md
# Configurable asynchronous serial transceiver

This block is a full-duplex asynchronous serial transmitter and receiver. It handles one character at a time in each direction. Four format inputs are read at run time. They choose 7 or 8 data bits, whether a parity bit is present, even or odd parity, and one or two stop bits. Every frame opens with a single low start bit. Data goes least significant bit first. The line idles high. A frame is 9 to 12 bit periods long.

Both directions are timed by a 16x bit-rate tick, and one bit period is 16 ticks. The tick comes from one of two sources:
- an internal divider that fires every `div_i + 1` clock cycles;
- the rising edges of an external clock input, which must run at 16 times the bit rate.

When the internal source is in use, the tick can also be driven out on a pin.

A byte is sent by pulsing `tx_wr_i` while `tx_busy_o` is low. A received character appears on `rx_data_o` with a one-cycle `rx_valid_o` strobe. It comes with parity and framing flags that are held until the next character.

Top module: `cfg_uart_top`

## Requirements
- R1: After reset, `tx_o` is high, and `tx_busy_o`, `rx_valid_o` and `clk16_o` are low.
- R2: A transmitted frame has these bits, in this order:
  - one low start bit;
  - the data bits, least significant bit first, 8 of them when `len7_i`=0 and 7 when `len7_i`=1;
  - one parity bit, only when `par_en_i`=1;
  - one high stop bit when `stop2_i`=0, or two when `stop2_i`=1.

  Each bit lasts 16 ticks.
- R3: The parity bit covers the data bits only. With `par_odd_i`=0 the total number of ones in data plus parity is even. With `par_odd_i`=1 it is odd.
- R4: `tx_busy_o` rises, and `tx_o` falls, in the cycle after an accepted write. `tx_busy_o` stays high until the last stop bit ends. While it is low, `tx_o` is high. A write made while `tx_busy_o` is high is ignored and sends nothing.
- R5: The receiver decodes a frame in the selected format and pulses `rx_valid_o` for one cycle after the middle of the last stop bit. `rx_data_o` then holds the character. For 7-bit characters, bit 7 of `rx_data_o` is 0.
- R6: `rx_perr_o` is 1 with a received character when parity is enabled and the received parity bit does not match the data. Otherwise it is 0.
- R7: `rx_ferr_o` is 1 with a received character when any expected stop bit was sampled low.
- R8: A low pulse on `rx_i` that is high again at the middle of the start bit (8 ticks after the falling edge) is discarded and produces no `rx_valid_o`.
- R9: With `clk_sel_ext_i`=0 the tick fires once every `div_i`+1 clock cycles. With `clk_out_en_i`=1, `clk16_o` pulses once per tick. With `clk_sel_ext_i`=1 or `clk_out_en_i`=0, `clk16_o` stays low.
- R10: With `clk_sel_ext_i`=1 the tick fires on each rising edge of `ext_clk_i`, so one bit period is 16 cycles of `ext_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Internal tick divider; period is div_i+1 cycles |
| clk_sel_ext_i | input | 1 | 1 selects the external 16x clock |
| ext_clk_i | input | 1 | External 16x bit-rate clock |
| clk_out_en_i | input | 1 | Enables the 16x clock output when the internal source is selected |
| clk16_o | output | 1 | 16x clock output, one pulse per tick |
| len7_i | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_en_i | input | 1 | 1 adds a parity bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| stop2_i | input | 1 | 1 selects two stop bits |
| tx_data_i | input | 8 | Byte to send |
| tx_wr_i | input | 1 | Write strobe for tx_data_i |
| tx_busy_o | output | 1 | Transmitter is sending a frame |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |
| rx_data_o | output | 8 | Last received character |
| rx_valid_o | output | 1 | One-cycle strobe for a new character |
| rx_perr_o | output | 1 | Parity error of the last character |
| rx_ferr_o | output | 1 | Framing error of the last character |

## Verification
The transmitter result is due one cycle after the write:
- `tx_o` goes low and `tx_busy_o` goes high in that cycle;
- each later bit starts 16 ticks after the one before.

The first tick can arrive up to one divider period early, so every bit may be shifted early by that much. The bench therefore compares each bit at the middle of its nominal period, measured from where it sees the start edge, which leaves a margin of half a bit.

The receiver result is due about the frame length minus half a bit after the start edge, plus the three synchronizer cycles. The bench waits for the strobe within a window one bit longer than the frame. It then compares the data and both flags at the strobe. For the glitch and ignored-write cases, it watches the outputs over a full frame time and expects no strobe and no extra frame.

// File: rtl/cfg_uart_pkg.sv
package cfg_uart_pkg;
  localparam int unsigned TICKS_PER_BIT = 16;
  localparam int unsigned TCNT_W        = $clog2(TICKS_PER_BIT);
  localparam int unsigned DATA_W        = 8;
  localparam int unsigned BCNT_W        = $clog2(DATA_W);

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } frame_fmt_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } ser_state_e;

  function automatic logic [DATA_W-1:0] mask_data(logic [DATA_W-1:0] d, frame_fmt_t f);
    return f.len7 ? {1'b0, d[DATA_W-2:0]} : d;
  endfunction

  function automatic logic par_calc(logic [DATA_W-1:0] d, frame_fmt_t f);
    return (^mask_data(d, f)) ^ f.par_odd;
  endfunction
endpackage

// File: rtl/cfg_uart_tick.sv
module cfg_uart_tick #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_sel_i,
  input  logic             ext_clk_i,
  input  logic             out_en_i,
  output logic             tick_o,
  output logic             clk16_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       ext_sh_q;  // two sync stages plus edge history
  logic             int_tick, ext_tick, clk16_q;

  assign int_tick = (cnt_q >= div_i);
  assign ext_tick = ext_sh_q[1] & ~ext_sh_q[2];
  assign tick_o   = ext_sel_i ? ext_tick : int_tick;
  assign clk16_o  = clk16_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      ext_sh_q <= '0;
      clk16_q  <= 1'b0;
    end else begin
      cnt_q    <= int_tick ? '0 : cnt_q + 1'b1;
      ext_sh_q <= {ext_sh_q[1:0], ext_clk_i};
      clk16_q  <= int_tick & out_en_i & ~ext_sel_i;
    end
  end
endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
  import cfg_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  frame_fmt_t        fmt_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wr_i,
  output logic              busy_o,
  output logic              tx_o
);
  ser_state_e        st_q;
  frame_fmt_t        fmt_q;
  logic [DATA_W-1:0] sr_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              par_q, tx_q;
  logic              bit_end;
  logic [BCNT_W-1:0] last_bit;

  assign bit_end  = tick_i && (tcnt_q == TCNT_W'(TICKS_PER_BIT - 1));
  assign last_bit = fmt_q.len7 ? BCNT_W'(DATA_W - 2) : BCNT_W'(DATA_W - 1);
  assign busy_o   = (st_q != ST_IDLE);
  assign tx_o     = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      fmt_q  <= '0;
      sr_q   <= '0;
      tcnt_q <= '0;
      bcnt_q <= '0;
      par_q  <= 1'b0;
      tx_q   <= 1'b1;
    end else if (st_q == ST_IDLE) begin
      if (wr_i) begin
        st_q   <= ST_START;
        fmt_q  <= fmt_i;
        sr_q   <= data_i;
        par_q  <= par_calc(data_i, fmt_i);
        tcnt_q <= '0;
        bcnt_q <= '0;
        tx_q   <= 1'b0;
      end
    end else begin
      if (tick_i) tcnt_q <= tcnt_q + 1'b1;
      if (bit_end) begin
        unique case (st_q)
          ST_START: begin
            st_q <= ST_DATA;
            tx_q <= sr_q[0];
          end
          ST_DATA: begin
            if (bcnt_q == last_bit) begin
              st_q <= fmt_q.par_en ? ST_PAR : ST_STOP1;
              tx_q <= fmt_q.par_en ? par_q : 1'b1;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
              sr_q   <= sr_q >> 1;
              tx_q   <= sr_q[1];
            end
          end
          ST_PAR: begin
            st_q <= ST_STOP1;
            tx_q <= 1'b1;
          end
          ST_STOP1: st_q <= fmt_q.stop2 ? ST_STOP2 : ST_IDLE;
          default:  st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_uart_rx.sv
module cfg_uart_rx
  import cfg_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  frame_fmt_t        fmt_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              len7_o
);
  localparam int unsigned MID = TICKS_PER_BIT / 2 - 1;

  ser_state_e        st_q;
  frame_fmt_t        fmt_q;
  logic [DATA_W-1:0] sr_q, asm_data;
  logic [TCNT_W-1:0] tcnt_q;
  logic [BCNT_W-1:0] bcnt_q, last_bit;
  logic              meta_q, rx_s_q, rx_prev_q;
  logic              perr_q, ferr_q;
  logic              bit_mid;

  assign bit_mid  = tick_i && (tcnt_q == TCNT_W'(TICKS_PER_BIT - 1));
  assign last_bit = fmt_q.len7 ? BCNT_W'(DATA_W - 2) : BCNT_W'(DATA_W - 1);
  // 7-bit characters end up in the upper bits of the shift register
  assign asm_data = fmt_q.len7 ? {1'b0, sr_q[DATA_W-1:1]} : sr_q;
  assign len7_o   = fmt_q.len7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q    <= 1'b1;
      rx_s_q    <= 1'b1;
      rx_prev_q <= 1'b1;
    end else begin
      meta_q    <= rx_i;
      rx_s_q    <= meta_q;
      rx_prev_q <= rx_s_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      fmt_q   <= '0;
      sr_q    <= '0;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (rx_prev_q && !rx_s_q) begin
          st_q   <= ST_START;
          fmt_q  <= fmt_i;
          tcnt_q <= '0;
          bcnt_q <= '0;
          perr_q <= 1'b0;
          ferr_q <= 1'b0;
        end
      end else if (st_q == ST_START) begin
        if (tick_i) begin
          if (tcnt_q == TCNT_W'(MID)) begin
            tcnt_q <= '0;
            st_q   <= rx_s_q ? ST_IDLE : ST_DATA;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
      end else begin
        if (tick_i) tcnt_q <= tcnt_q + 1'b1;
        if (bit_mid) begin
          unique case (st_q)
            ST_DATA: begin
              sr_q <= {rx_s_q, sr_q[DATA_W-1:1]};
              if (bcnt_q == last_bit) st_q <= fmt_q.par_en ? ST_PAR : ST_STOP1;
              else bcnt_q <= bcnt_q + 1'b1;
            end
            ST_PAR: begin
              perr_q <= rx_s_q ^ par_calc(asm_data, fmt_q);
              st_q   <= ST_STOP1;
            end
            ST_STOP1: begin
              if (fmt_q.stop2) begin
                ferr_q <= ~rx_s_q;
                st_q   <= ST_STOP2;
              end else begin
                st_q    <= ST_IDLE;
                valid_o <= 1'b1;
                data_o  <= asm_data;
                perr_o  <= perr_q;
                ferr_o  <= ~rx_s_q;
              end
            end
            default: begin
              st_q    <= ST_IDLE;
              valid_o <= 1'b1;
              data_o  <= asm_data;
              perr_o  <= perr_q;
              ferr_o  <= ferr_q | ~rx_s_q;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cfg_uart_top.sv
module cfg_uart_top
  import cfg_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clk_sel_ext_i,
  input  logic             ext_clk_i,
  input  logic             clk_out_en_i,
  output logic             clk16_o,
  input  logic             len7_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             stop2_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_wr_i,
  output logic             tx_busy_o,
  output logic             tx_o,
  input  logic             rx_i,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  output logic             rx_perr_o,
  output logic             rx_ferr_o
);
  frame_fmt_t fmt;
  logic       tick;
  logic       rx_len7;

  assign fmt = '{len7: len7_i, par_en: par_en_i, par_odd: par_odd_i, stop2: stop2_i};

  cfg_uart_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .div_i,
    .ext_sel_i (clk_sel_ext_i),
    .ext_clk_i,
    .out_en_i  (clk_out_en_i),
    .tick_o    (tick),
    .clk16_o
  );

  cfg_uart_tx u_tx (
    .clk_i, .rst_ni,
    .tick_i (tick),
    .fmt_i  (fmt),
    .data_i (tx_data_i),
    .wr_i   (tx_wr_i),
    .busy_o (tx_busy_o),
    .tx_o
  );

  cfg_uart_rx u_rx (
    .clk_i, .rst_ni,
    .tick_i  (tick),
    .fmt_i   (fmt),
    .rx_i,
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .perr_o  (rx_perr_o),
    .ferr_o  (rx_ferr_o),
    .len7_o  (rx_len7)
  );
endmodule

// File: rtl/cfg_uart_chk.sv
module cfg_uart_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_busy_o,
  input logic       tx_o,
  input logic       rx_valid_o,
  input logic [7:0] rx_data_o,
  input logic       rx_len7,
  input logic       clk_sel_ext_i,
  input logic       clk16_o
);
  // R4
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> tx_o);
  // R4
  start_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_o) |-> !tx_o);
  // R5
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R5
  seven_bit_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rx_len7) |-> !rx_data_o[7]);
  // R9
  ext_no_clkout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clk_sel_ext_i) |-> !clk16_o);
endmodule

bind cfg_uart_top cfg_uart_chk u_chk (
  .clk_i, .rst_ni, .tx_busy_o, .tx_o, .rx_valid_o, .rx_data_o,
  .rx_len7, .clk_sel_ext_i, .clk16_o
);

// File: tb/cfg_uart_top_tb_top.sv
`timescale 1ns/1ps
module cfg_uart_top_tb_top;
  localparam int DIV_W = 12;
  localparam int EXT_P = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic clk_sel_ext = 1'b0, ext_clk = 1'b0, clk_out_en = 1'b0, clk16;
  logic len7 = 0, par_en = 0, par_odd = 0, stop2 = 0;
  logic [7:0] tx_data = '0;
  logic tx_wr = 0, tx_busy, tx_line;
  logic rx_drv = 1'b1, loop_en = 1'b0, rx_line;
  logic [7:0] rx_data;
  logic rx_valid, rx_perr, rx_ferr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;
  initial forever begin repeat (EXT_P/2) @(posedge clk); ext_clk = ~ext_clk; end
  assign rx_line = loop_en ? tx_line : rx_drv;

  cfg_uart_top #(.DIV_W(DIV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .clk_sel_ext_i(clk_sel_ext),
    .ext_clk_i(ext_clk), .clk_out_en_i(clk_out_en), .clk16_o(clk16),
    .len7_i(len7), .par_en_i(par_en), .par_odd_i(par_odd), .stop2_i(stop2),
    .tx_data_i(tx_data), .tx_wr_i(tx_wr), .tx_busy_o(tx_busy), .tx_o(tx_line),
    .rx_i(rx_line), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_perr_o(rx_perr), .rx_ferr_o(rx_ferr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_data(logic [7:0] d);
    return len7 ? {1'b0, d[6:0]} : d;
  endfunction

  function automatic logic [11:0] exp_frame(logic [7:0] d, output int n);
    logic [11:0] v = '0;
    int nb = len7 ? 7 : 8;
    n = 1;
    for (int i = 0; i < nb; i++) begin v[n] = d[i]; n++; end
    if (par_en) begin v[n] = (^exp_data(d)) ^ par_odd; n++; end
    v[n] = 1'b1; n++;
    if (stop2) begin v[n] = 1'b1; n++; end
    return v;
  endfunction

  task automatic set_fmt(input logic [3:0] f);
    {len7, par_en, par_odd, stop2} = f;
  endtask

  // write a byte and sample every bit at its nominal middle
  task automatic tx_frame(input logic [7:0] d, input int bp, input bit poke, input string req);
    logic [11:0] exp_v, got = '0;
    int n, lows = 0;
    exp_v = exp_frame(d, n);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    chk(tx_busy === 1'b1, "R4", "busy after write", tx_busy, 1);
    chk(tx_line === 1'b0, "R4", "start bit on accept", tx_line, 0);
    repeat (bp/2 - 1) @(negedge clk);
    got[0] = tx_line;
    for (int k = 1; k < n; k++) begin
      if (poke && k == 2) begin
        tx_data = ~d; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
        repeat (bp - 1) @(negedge clk);
      end else repeat (bp) @(negedge clk);
      got[k] = tx_line;
    end
    chk(got == exp_v, req, "tx frame bits", got, exp_v);
    repeat (bp/2 + 2) @(negedge clk);
    chk(tx_busy === 1'b0, "R4", "busy after last stop", tx_busy, 0);
    if (poke) begin
      repeat (2 * 12 * bp) begin @(negedge clk); if (tx_line !== 1'b1) lows++; end
      chk(lows == 0, "R4", "write while busy ignored", lows, 0);
    end
  endtask

  task automatic rx_send(input logic [7:0] d, input int bp, input bit bad_par, input bit bad_stop);
    logic [11:0] v;
    int n;
    v = exp_frame(d, n);
    if (bad_par) v[len7 ? 8 : 9] = ~v[len7 ? 8 : 9];
    if (bad_stop) v[n-1] = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rx_drv = v[k];
      repeat (bp - 1) @(negedge clk);
    end
    @(negedge clk); rx_drv = 1'b1;
  endtask

  task automatic wait_rx(input int maxc, output bit got, output logic [7:0] d,
                         output logic pe, output logic fe);
    got = 0; d = '0; pe = 0; fe = 0;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (rx_valid) begin got = 1; d = rx_data; pe = rx_perr; fe = rx_ferr; break; end
    end
  endtask

  task automatic rx_case(input logic [7:0] d, input int bp, input bit bp_err, input bit bs_err,
                         input string req);
    bit got; logic [7:0] rd; logic pe, fe;
    fork
      rx_send(d, bp, bp_err, bs_err);
      wait_rx(14 * bp, got, rd, pe, fe);
    join
    chk(got, req, "rx strobe seen", got, 1);
    chk(rd == exp_data(d), req, "rx data", rd, exp_data(d));
    chk(pe == bp_err, "R6", "rx parity flag", pe, bp_err);
    chk(fe == bs_err, "R7", "rx framing flag", fe, bs_err);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt, bp;
    bit got; logic [7:0] rd, d; logic pe, fe;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(tx_line === 1'b1, "R1", "tx idle in reset", tx_line, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_line === 1'b1 && tx_busy === 1'b0, "R1", "tx idle after reset", {tx_line, tx_busy}, 2'b10);
    chk(rx_valid === 1'b0 && clk16 === 1'b0, "R1", "rx strobe / clk out low", {rx_valid, clk16}, 0);

    // R9 clock output rate
    div = 12'd4; clk_out_en = 1'b1;
    repeat (20) @(negedge clk);
    cnt = 0; repeat (500) begin @(negedge clk); if (clk16) cnt++; end
    chk(cnt == 100, "R9", "clk16 pulses in 500 cycles", cnt, 100);
    clk_out_en = 1'b0; repeat (4) @(negedge clk);
    cnt = 0; repeat (200) begin @(negedge clk); if (clk16) cnt++; end
    chk(cnt == 0, "R9", "clk16 disabled", cnt, 0);
    clk_out_en = 1'b1; clk_sel_ext = 1'b1; repeat (4) @(negedge clk);
    cnt = 0; repeat (200) begin @(negedge clk); if (clk16) cnt++; end
    chk(cnt == 0, "R9", "clk16 low on external source", cnt, 0);
    clk_sel_ext = 1'b0; clk_out_en = 1'b0;

    // R2 / R3 directed tx formats, internal tick
    div = 12'd3; bp = 16 * 4;
    set_fmt(4'b0000); tx_frame(8'hA5, bp, 0, "R2");
    set_fmt(4'b1101); tx_frame(8'hC3, bp, 0, "R2");
    set_fmt(4'b0100); tx_frame(8'h17, bp, 0, "R3");
    set_fmt(4'b0110); tx_frame(8'h17, bp, 0, "R3");
    set_fmt(4'b1111); tx_frame(8'hFF, bp, 0, "R3");
    set_fmt(4'b0001); tx_frame(8'h5A, bp, 1, "R4");

    // R10 external tick
    clk_sel_ext = 1'b1; repeat (4) @(negedge clk);
    set_fmt(4'b0101); tx_frame(8'h39, 16 * EXT_P, 0, "R10");
    rx_case(8'h6E, 16 * EXT_P, 0, 0, "R10");
    clk_sel_ext = 1'b0; repeat (4) @(negedge clk);

    // receiver directed cases
    set_fmt(4'b1000); rx_case(8'hD2, bp, 0, 0, "R5");
    set_fmt(4'b0100); rx_case(8'h81, bp, 1, 0, "R6");
    set_fmt(4'b1110); rx_case(8'h4C, bp, 1, 0, "R6");
    set_fmt(4'b0001); rx_case(8'h99, bp, 0, 1, "R7");
    set_fmt(4'b0000); rx_case(8'h33, bp, 0, 1, "R7");

    // R8 glitch rejection
    @(negedge clk); rx_drv = 1'b0;
    repeat (4 * 4) @(negedge clk); rx_drv = 1'b1;
    wait_rx(14 * bp, got, rd, pe, fe);
    chk(!got, "R8", "glitch produces no strobe", got, 0);
    rx_case(8'hE7, bp, 0, 0, "R8");

    // random loopback
    loop_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      div = 12'($urandom_range(0, 3)); bp = 16 * (int'(div) + 1);
      set_fmt(4'($urandom_range(0, 15)));
      d = 8'($urandom);
      repeat (3) @(negedge clk);
      tx_data = d; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
      wait_rx(14 * bp, got, rd, pe, fe);
      chk(got && rd == exp_data(d), "R5", "loopback data", rd, exp_data(d));
      chk(!pe && !fe, "R6", "loopback clean flags", {pe, fe}, 0);
      while (tx_busy) @(negedge clk);
    end
    loop_en = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule